// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block is the host end of an enhanced parallel port link. A local controller asks for one access at a time, naming the target register (address or data), the direction, and for writes the byte to send. The engine then runs one complete cable cycle, with all timing generated in hardware. The cable side has four active-low outputs: a direction line, an address strobe, a data strobe and a peripheral reset. It also has an 8-bit bus, driven through an output enable, and two inputs: the peripheral's wait line and its interrupt line.

Every cycle is fully interlocked with wait. The strobe is asserted only once wait is seen low, and it is held until wait is seen high. The cycle counts as finished only when wait has dropped again after the strobe was released. Wait and interrupt both pass through a two-flop synchronizer. A programmable limit on the number of cycles spent in any one waiting phase aborts a stuck transfer and raises a timeout flag.

The controller is a state machine with these states:
- `ST_IDLE`: nothing on the cable.
- `ST_DIR`: direction line set.
- `ST_DRIVE`: bus driven for writes; waits for wait low.
- `ST_STROBE`: strobe asserted; waits for wait high.
- `ST_HOLD`: strobe released; waits for wait low.
- `ST_ABORT`: timeout exit.

It has these transitions:
- `ST_IDLE`→`ST_DIR` on an accepted access.
- `ST_DIR`→`ST_DRIVE` always.
- `ST_DRIVE`→`ST_STROBE` on wait low.
- `ST_STROBE`→`ST_HOLD` on wait high.
- `ST_HOLD`→`ST_IDLE` on wait low.
- Any of the three waiting states →`ST_ABORT` on limit expiry. Progress on wait wins over expiry in the same cycle.
- `ST_ABORT`→`ST_IDLE` always.

Top module: `epp_host_engine`

## Requirements
- R1: While `rst` is high and after it, while idle: `epp_wr_n`, `epp_astb_n` and `epp_dstb_n` are 1, `bus_oe` is 0, and `busy`, `done` and `tmo_flag` are 0. `epp_prst_n` is 0 while `rst` is high and 1 after release.
- R2: An access with `acc_data_sel`=0 pulses only `epp_astb_n` low, exactly once. An access with `acc_data_sel`=1 pulses only `epp_dstb_n` low, exactly once. The two strobes are never low together.
- R3: On a write (`acc_write`=1), `epp_wr_n` goes low first. `bus_oe` rises in a later cycle with `bus_out` equal to `acc_wbyte`. The strobe falls in a still later cycle. Direction and enable stay set while the strobe is low.
- R4: On a read (`acc_write`=0), `epp_wr_n` stays 1 and `bus_oe` stays 0. `rd_data` takes the `bus_in` value present when wait is first seen high while the strobe is low.
- R5: The strobe falls only after synchronized wait has been seen low. It stays low until synchronized wait is seen high, unless a timeout aborts the cycle.
- R6: A normal cycle ends with a one-cycle `done` pulse and `busy` falling, only after wait has returned low following strobe release.
- R7: `acc_en` while `busy` is 1 is ignored: it produces no further strobe and does not change the peripheral's registers.
- R8: With `tmo_limit`=N>0, a cycle held for N cycles in one waiting state is aborted. All strobes are released, `busy` falls, `done` does not pulse, and `tmo_flag` becomes 1. `tmo_limit`=0 disables the limit. The next accepted access clears `tmo_flag`.
- R9: `irq` equals `intr_in` delayed by exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Request one access (taken when not busy) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_data_sel | input | 1 | 1 = data register, 0 = address register |
| acc_wbyte | input | DATA_W | Byte to write |
| tmo_limit | input | TMO_W | Cycles allowed per waiting phase, 0 = no limit |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| rd_data | output | DATA_W | Last byte read |
| tmo_flag | output | 1 | Last cycle was aborted by the limit |
| irq | output | 1 | Synchronized interrupt input |
| epp_wr_n | output | 1 | Direction line, low = write |
| epp_astb_n | output | 1 | Address strobe, active low |
| epp_dstb_n | output | 1 | Data strobe, active low |
| epp_prst_n | output | 1 | Peripheral reset, active low |
| bus_out | output | DATA_W | Bus value driven when enabled |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | DATA_W | Bus value sampled on reads |
| wait_in | input | 1 | Peripheral wait/acknowledge |
| intr_in | input | 1 | Peripheral interrupt |

## Verification
A peripheral model answers with random acknowledge delays of zero to three cycles in both handshake phases. Random mixes of reads and writes go to both registers, so a swapped strobe or a lost byte shows up as a register mismatch on read-back. Directed cases do the rest:
- A peripheral that never acknowledges separates abort in the strobe phase from normal completion.
- A peripheral that never releases wait separates abort in the release phase from completion.
- A disabled limit separates patient waiting from an abort.
- A request injected mid-cycle tells apart blocking from acceptance.
- An interrupt edge pins the two-stage synchronizer delay.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DIR    = 3'd1,
        ST_DRIVE  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_ABORT  = 3'd5
    } epp_state_t;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/epp_tmo_timer.sv
module epp_tmo_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign expired = run && (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
    import epp_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_write,
    input  logic              acc_data_sel,
    input  logic [DATA_W-1:0] acc_wbyte,
    input  logic              wait_s,
    input  logic              expired,
    input  logic [DATA_W-1:0] bus_in,
    output logic              busy,
    output logic              done,
    output logic              tmo_flag,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_n,
    output logic              astb_n,
    output logic              dstb_n,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_out,
    output logic              tmr_run,
    output logic              tmr_restart
);
    epp_state_t st, st_nxt;

    logic              req_write;
    logic              req_sel;
    logic [DATA_W-1:0] req_byte;
    logic              take;
    logic              dir_w;
    logic              dir_sel;

    assign take    = (st == ST_IDLE) && acc_en;
    assign dir_w   = (st == ST_IDLE) ? acc_write    : req_write;
    assign dir_sel = (st == ST_IDLE) ? acc_data_sel : req_sel;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // next-state decision; progress on wait beats expiry
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (acc_en) st_nxt = ST_DIR;
            ST_DIR:    st_nxt = ST_DRIVE;
            ST_DRIVE: begin
                if (!wait_s)      st_nxt = ST_STROBE;
                else if (expired) st_nxt = ST_ABORT;
            end
            ST_STROBE: begin
                if (wait_s)       st_nxt = ST_HOLD;
                else if (expired) st_nxt = ST_ABORT;
            end
            ST_HOLD: begin
                if (!wait_s)      st_nxt = ST_IDLE;
                else if (expired) st_nxt = ST_ABORT;
            end
            ST_ABORT:  st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // registered cable outputs, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n   <= 1'b1;
            astb_n <= 1'b1;
            dstb_n <= 1'b1;
            bus_oe <= 1'b0;
        end else begin
            wr_n   <= !(dir_w && (st_nxt inside {ST_DIR, ST_DRIVE, ST_STROBE, ST_HOLD}));
            bus_oe <= dir_w && (st_nxt inside {ST_DRIVE, ST_STROBE, ST_HOLD});
            astb_n <= !((st_nxt == ST_STROBE) && !dir_sel);
            dstb_n <= !((st_nxt == ST_STROBE) && dir_sel);
        end
    end

    // request capture, read latch, completion and timeout status
    always_ff @(posedge clk) begin
        if (rst) begin
            req_write <= 1'b0;
            req_sel   <= 1'b0;
            req_byte  <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
            tmo_flag  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take) begin
                req_write <= acc_write;
                req_sel   <= acc_data_sel;
                req_byte  <= acc_wbyte;
                tmo_flag  <= 1'b0;
            end
            if ((st == ST_STROBE) && wait_s && !req_write) begin
                rd_data <= bus_in;
            end
            if ((st == ST_HOLD) && !wait_s) begin
                done <= 1'b1;
            end
            if (st == ST_ABORT) begin
                tmo_flag <= 1'b1;
            end
        end
    end

    assign busy        = (st != ST_IDLE);
    assign bus_out     = req_byte;
    assign tmr_run     = st inside {ST_DRIVE, ST_STROBE, ST_HOLD};
    assign tmr_restart = (st_nxt != st);
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine #(
    parameter int DATA_W      = 8,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_write,
    input  logic              acc_data_sel,
    input  logic [DATA_W-1:0] acc_wbyte,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              tmo_flag,
    output logic              irq,
    output logic              epp_wr_n,
    output logic              epp_astb_n,
    output logic              epp_dstb_n,
    output logic              epp_prst_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              wait_in,
    input  logic              intr_in
);
    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0] sync_q;
    logic              wait_s;
    logic              expired;
    logic              tmr_run;
    logic              tmr_restart;

    epp_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({intr_in, wait_in}),
        .q   (sync_q)
    );

    assign wait_s = sync_q[0];
    assign irq    = sync_q[1];

    epp_tmo_timer #(.CNT_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .restart (tmr_restart),
        .limit   (tmo_limit),
        .expired (expired)
    );

    epp_cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .acc_en       (acc_en),
        .acc_write    (acc_write),
        .acc_data_sel (acc_data_sel),
        .acc_wbyte    (acc_wbyte),
        .wait_s       (wait_s),
        .expired      (expired),
        .bus_in       (bus_in),
        .busy         (busy),
        .done         (done),
        .tmo_flag     (tmo_flag),
        .rd_data      (rd_data),
        .wr_n         (epp_wr_n),
        .astb_n       (epp_astb_n),
        .dstb_n       (epp_dstb_n),
        .bus_oe       (bus_oe),
        .bus_out      (bus_out),
        .tmr_run      (tmr_run),
        .tmr_restart  (tmr_restart)
    );

    always_ff @(posedge clk) begin
        epp_prst_n <= !rst;
    end
endmodule

// File: rtl/epp_host_engine_chk.sv
module epp_host_engine_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic tmo_flag,
    input logic irq,
    input logic intr_in,
    input logic epp_wr_n,
    input logic epp_astb_n,
    input logic epp_dstb_n,
    input logic bus_oe,
    input logic wait_s
);
    logic       stb_any;
    logic [1:0] since_rst;

    assign stb_any = !(epp_astb_n && epp_dstb_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (epp_astb_n && epp_dstb_n && epp_wr_n && !bus_oe));

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !(!epp_astb_n && !epp_dstb_n));

    p_write_setup_r3: assert property (@(posedge clk) disable iff (rst)
        (stb_any && !epp_wr_n) |-> bus_oe);

    p_data_first_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(stb_any) && !epp_wr_n) |-> $past(bus_oe));

    p_read_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !epp_wr_n);

    p_strobe_wait_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stb_any) |-> $past(!wait_s));

    p_done_after_release_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !stb_any && $past(!wait_s)));

    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag) |-> (!busy && !stb_any && !done));

    p_irq_delay_r9: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (irq == $past(intr_in, 2)));
endmodule

bind epp_host_engine epp_host_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .tmo_flag   (tmo_flag),
    .irq        (irq),
    .intr_in    (intr_in),
    .epp_wr_n   (epp_wr_n),
    .epp_astb_n (epp_astb_n),
    .epp_dstb_n (epp_dstb_n),
    .bus_oe     (bus_oe),
    .wait_s     (wait_s)
);

// File: tb/epp_host_engine_tb.sv
module epp_host_engine_tb_top;
    localparam int DW = 8;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_en = 1'b0;
    logic          acc_write = 1'b0;
    logic          acc_data_sel = 1'b0;
    logic [DW-1:0] acc_wbyte = '0;
    logic [TW-1:0] tmo_limit = '0;
    logic          busy, done, tmo_flag, irq;
    logic [DW-1:0] rd_data, bus_out;
    logic          epp_wr_n, epp_astb_n, epp_dstb_n, epp_prst_n, bus_oe;
    logic [DW-1:0] bus_in = '0;
    logic          intr_in = 1'b0;

    // peripheral model state
    logic          pwait = 1'b0;
    logic [1:0]    dly = '0;
    logic          hang_hi = 1'b0;
    logic          hang_lo = 1'b0;
    logic          allow_abort = 1'b0;
    logic          prev_s = 1'b0;
    logic          s_any;
    logic [DW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;
    int            n_astb = 0;
    int            n_dstb = 0;
    logic          cur_wr = 1'b0;
    logic [DW-1:0] cur_byte = '0;

    logic [DW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #5 clk = ~clk;

    epp_host_engine #(.DATA_W(DW), .TMO_W(TW)) dut_i (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_write(acc_write),
        .acc_data_sel(acc_data_sel), .acc_wbyte(acc_wbyte), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .rd_data(rd_data), .tmo_flag(tmo_flag), .irq(irq),
        .epp_wr_n(epp_wr_n), .epp_astb_n(epp_astb_n), .epp_dstb_n(epp_dstb_n),
        .epp_prst_n(epp_prst_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .wait_in(pwait), .intr_in(intr_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_read(input logic sel);
        return sel ? m_data : m_addr;
    endfunction

    // peripheral: acknowledges strobes after a random delay, checks cable order
    always @(negedge clk) begin
        if (rst) begin
            pwait = 1'b0;
            dly = '0;
            prev_s = 1'b0;
        end else begin
            s_any = !epp_astb_n || !epp_dstb_n;
            if (s_any && !prev_s) begin
                if (!epp_astb_n) n_astb++; else n_dstb++;
                chk(pwait == 1'b0, "R5 strobe while wait low", pwait, 0);
                if (cur_wr)
                    chk(!epp_wr_n && bus_oe && bus_out == cur_byte,
                        "R3 write setup at strobe", {epp_wr_n, bus_oe, bus_out}, {2'b01, cur_byte});
                else
                    chk(epp_wr_n && !bus_oe, "R4 read keeps bus released",
                        {epp_wr_n, bus_oe}, 2'b10);
            end
            if (!s_any && prev_s && !allow_abort)
                chk(pwait == 1'b1, "R5 strobe held until wait high", pwait, 1);
            prev_s = s_any;
            if (!pwait && s_any && !hang_hi) begin
                if (dly == 0) begin
                    if (!epp_wr_n) begin
                        if (!epp_astb_n) p_addr = bus_out; else p_data = bus_out;
                    end else begin
                        bus_in = !epp_astb_n ? p_addr : p_data;
                    end
                    pwait = 1'b1;
                    dly = 2'($urandom % 4);
                end else begin
                    dly = dly - 2'd1;
                end
            end else if (pwait && !s_any && !hang_lo) begin
                if (dly == 0) begin
                    pwait = 1'b0;
                    dly = 2'($urandom % 4);
                end else begin
                    dly = dly - 2'd1;
                end
            end
        end
    end

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            summary_and_end();
        end
    end

    // one access; intrude=1 injects a request while busy (R7)
    task automatic do_access(input logic sel, input logic wr, input logic [DW-1:0] b,
                             input bit intrude);
        int a0, d0, n;
        bit seen;
        logic [DW-1:0] pa0;
        @(negedge clk);
        while (busy) @(negedge clk);
        cur_wr = wr;
        cur_byte = b;
        a0 = n_astb;
        d0 = n_dstb;
        acc_en = 1'b1; acc_write = wr; acc_data_sel = sel; acc_wbyte = b;
        @(negedge clk);
        acc_en = 1'b0;
        chk(busy == 1'b1, "R6 busy after accept", busy, 1);
        pa0 = p_addr;
        if (intrude) begin
            @(negedge clk);
            acc_en = 1'b1; acc_write = 1'b1; acc_data_sel = 1'b0; acc_wbyte = ~b;
            @(negedge clk);
            acc_en = 1'b0;
        end
        seen = 0;
        n = 0;
        while (!seen && n < 500) begin
            if (done) seen = 1; else begin @(negedge clk); n++; end
        end
        chk(seen, "R6 done pulse seen", seen, 1);
        chk(!busy && pwait == 1'b0, "R6 complete only after wait low", {busy, pwait}, 0);
        chk(tmo_flag == 1'b0, "R8 no timeout on normal cycle", tmo_flag, 0);
        chk(sel ? (n_dstb == d0 + 1 && n_astb == a0) : (n_astb == a0 + 1 && n_dstb == d0),
            "R2 single matching strobe", {n_astb - a0, n_dstb - d0}, sel ? 1 : 256);
        if (wr) begin
            if (sel) m_data = b; else m_addr = b;
            chk((sel ? p_data : p_addr) == b, "R3 peripheral got byte",
                sel ? p_data : p_addr, b);
        end else begin
            chk(rd_data == model_read(sel), "R4 read byte", rd_data, model_read(sel));
        end
        if (intrude) begin
            repeat (10) @(negedge clk);
            chk(!busy && n_astb + n_dstb == a0 + d0 + 1, "R7 request while busy ignored",
                n_astb + n_dstb - a0 - d0, 1);
            chk(sel || wr || p_addr == pa0, "R7 address register untouched", p_addr, pa0);
            chk(!sel || p_addr == m_addr, "R7 address register untouched", p_addr, m_addr);
        end
    endtask

    initial begin
        bit seen_done;
        int n;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(epp_wr_n && epp_astb_n && epp_dstb_n && !bus_oe, "R1 cable idle in reset",
            {epp_wr_n, epp_astb_n, epp_dstb_n, bus_oe}, 4'b1110);
        chk(!busy && !done && !tmo_flag, "R1 status clear in reset", {busy, done, tmo_flag}, 0);
        chk(epp_prst_n == 1'b0, "R1 peripheral reset low", epp_prst_n, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(epp_prst_n == 1'b1, "R1 peripheral reset released", epp_prst_n, 1);
        chk(epp_wr_n && epp_astb_n && epp_dstb_n && !bus_oe && !busy, "R1 idle after reset",
            {epp_wr_n, epp_astb_n, epp_dstb_n, bus_oe, busy}, 5'b11100);

        // R9: two-edge interrupt synchronizer
        intr_in = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R9 irq not yet after one edge", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq after two edges", irq, 1);
        intr_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R9 irq falls after two edges", irq, 0);

        // directed corners
        tmo_limit = 16'd0;
        do_access(1'b0, 1'b1, 8'h00, 0);
        do_access(1'b1, 1'b1, 8'hFF, 0);
        do_access(1'b0, 1'b0, 8'h00, 0);
        do_access(1'b1, 1'b0, 8'h00, 0);
        do_access(1'b1, 1'b1, 8'hA5, 1);
        do_access(1'b0, 1'b0, 8'h00, 1);

        // random mix
        for (int i = 0; i < 200; i++) begin
            do_access(1'($urandom % 2), 1'($urandom % 2), 8'($urandom), (i % 37) == 5);
        end

        // R8: stuck in strobe phase
        tmo_limit = 16'd20;
        hang_hi = 1'b1;
        allow_abort = 1'b1;
        @(negedge clk);
        acc_en = 1'b1; acc_write = 1'b1; acc_data_sel = 1'b1; acc_wbyte = 8'h3C; cur_wr = 1'b1;
        cur_byte = 8'h3C;
        @(negedge clk);
        acc_en = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R8 still waiting before limit", busy, 1);
        seen_done = 0;
        n = 0;
        while (busy && n < 200) begin
            @(negedge clk);
            if (done) seen_done = 1;
            n++;
        end
        chk(!busy && tmo_flag && !seen_done, "R8 abort in strobe phase",
            {busy, tmo_flag, seen_done}, 3'b010);
        chk(epp_astb_n && epp_dstb_n && epp_wr_n && !bus_oe, "R8 cable released on abort",
            {epp_astb_n, epp_dstb_n, epp_wr_n, bus_oe}, 4'b1110);
        hang_hi = 1'b0;

        // R8: limit disabled -> waits indefinitely; flag cleared on accept
        tmo_limit = 16'd0;
        hang_hi = 1'b1;
        @(negedge clk);
        acc_en = 1'b1; acc_write = 1'b0; acc_data_sel = 1'b1; cur_wr = 1'b0;
        @(negedge clk);
        acc_en = 1'b0;
        chk(tmo_flag == 1'b0, "R8 flag cleared by next accept", tmo_flag, 0);
        repeat (200) @(negedge clk);
        chk(busy == 1'b1 && tmo_flag == 1'b0, "R8 limit zero never aborts", {busy, tmo_flag}, 2'b10);
        allow_abort = 1'b0;
        hang_hi = 1'b0;
        seen_done = 0;
        n = 0;
        while (!seen_done && n < 200) begin
            @(negedge clk);
            if (done) seen_done = 1;
            n++;
        end
        chk(seen_done && rd_data == m_data, "R4 read completes after long stall", rd_data, m_data);

        // R8: stuck in release phase
        tmo_limit = 16'd20;
        hang_lo = 1'b1;
        allow_abort = 1'b1;
        @(negedge clk);
        acc_en = 1'b1; acc_write = 1'b0; acc_data_sel = 1'b0; cur_wr = 1'b0;
        @(negedge clk);
        acc_en = 1'b0;
        seen_done = 0;
        n = 0;
        while (busy && n < 200) begin
            @(negedge clk);
            if (done) seen_done = 1;
            n++;
        end
        chk(!busy && tmo_flag && !seen_done, "R8 abort in release phase",
            {busy, tmo_flag, seen_done}, 3'b010);
        hang_lo = 1'b0;
        allow_abort = 1'b0;
        repeat (10) @(negedge clk);
        do_access(1'b0, 1'b0, 8'h00, 0);

        summary_and_end();
    end
endmodule